// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous 32K x 8 Static RAM

This block turns single-word read and write requests, offered on a valid/ready handshake, into correctly timed pin activity for an asynchronous static RAM with a 15-bit address and an 8-bit data bus. Every datasheet delay is a nanosecond parameter. At elaboration it becomes a whole number of clock cycles, `ceil(ns * CLK_MHZ / 1000)`, and any nonzero value rounds to at least one cycle. Each phase of a cycle is then held for the resulting count by a shared down-counter. The defaults target a 70 ns grade at 125 MHz.

The sequencer has seven states. In `ST_IDLE` the block is ready and all strobes are high. A read goes `ST_IDLE -> ST_RD_ACT` on acceptance. Chip select and output enable are low in that state, and it is held for the longest of the address, select, output-enable access and read-cycle times. The next steps are `ST_RD_ACT -> ST_RD_DONE`, where the strobes rise and the captured byte is returned with a one-cycle valid pulse, and `ST_RD_DONE -> ST_RD_TURN -> ST_IDLE`. The turnaround state is used only when the memory's bus-release time is not already covered by the quiet phase at the start of a following write; otherwise the path is `ST_RD_DONE -> ST_IDLE`. A write goes `ST_IDLE -> ST_WR_HIZ`, with select and write enable low and the data driver off while the memory may still drive. It continues `ST_WR_HIZ -> ST_WR_DRV`, with the driver on, then `ST_WR_DRV -> ST_WR_REC`, where all strobes are high and the driver is off, and `ST_WR_REC -> ST_IDLE`.

All pin outputs come straight from flip-flops. Address and write data are registered on acceptance and held until the next acceptance, which can only happen while every strobe is high.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, chip select, write enable and output enable are high (inactive), the data driver enable is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A read holds chip select and output enable low for at least 70 ns, which is 9 cycles at 125 MHz. It returns the byte stored at the requested address with `rsp_valid` high for exactly one cycle. The pulse is seen 10 cycles after the request was offered to a ready controller.
- R3: Write enable stays high whenever output enable is low.
- R4: A write holds chip select and write enable low together for at least 50 ns, with output enable high throughout.
- R5: The data driver is enabled for at least 30 ns before write enable rises. It is disabled on the same clock edge on which write enable rises, and the memory stores the driven byte at that point.
- R6: The data driver is not enabled within 30 ns after write enable falls.
- R7: The data driver is never enabled while output enable is low.
- R8: The address and write data outputs do not change while chip select is low.
- R9: Consecutive falls of chip select are at least 70 ns apart.
- R10: After a read's strobes rise, the data driver is not enabled for at least 30 ns.
- R11: `req_ready` is 1 only while the controller is idle with all strobes high, and at most one request is in flight. Once a request is accepted, `req_ready` is 0 in the following cycle.
- R12: A write returns to ready 10 cycles after it was offered, which is the rounded phase lengths at 125 MHz: 4 cycles driver off, 4 cycles driver on and 1 cycle recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle; request taken on valid and ready |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read data |
| sram_addr | output | 15 | Address pins |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 8 | Data to memory |
| sram_dq_oe | output | 1 | Enable for the data bus driver |
| sram_dq_in | input | 8 | Data from memory |

## Verification
The assertions assume that reset is held for at least one clock edge before any strobe can change. They also assume that the request inputs are only sampled when `req_ready` is high, so a request that is held or changed while the controller is busy has no effect.

The bench meets these assumptions by driving requests on falling edges, raising `req_valid` only after it sees `req_ready` high and dropping it right after acceptance. Its memory model returns a corrupted byte until 70 ns of stable access have passed, so a read that samples too early shows up as a data mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACT,
        ST_RD_DONE,
        ST_RD_TURN,
        ST_WR_HIZ,
        ST_WR_DRV,
        ST_WR_REC
    } ctrl_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
        logic ready;
        logic rsp;
    } pin_ctl_t;

    function automatic int ns2cyc(input int ns, input int mhz);
        int c;
        if (ns <= 0) return 0;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic pin_ctl_t decode_pins(input ctrl_state_e st);
        pin_ctl_t p;
        p = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, ready: 1'b0, rsp: 1'b0};
        unique case (st)
            ST_IDLE:    p.ready = 1'b1;
            ST_RD_ACT:  begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
            ST_RD_DONE: p.rsp = 1'b1;
            ST_RD_TURN: ;
            ST_WR_HIZ:  begin p.cs_n = 1'b0; p.we_n = 1'b0; end
            ST_WR_DRV:  begin p.cs_n = 1'b0; p.we_n = 1'b0; p.dq_oe = 1'b1; end
            ST_WR_REC:  ;
            default:    p.ready = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_delay_cnt.sv
module sram_delay_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr   <= '0;
            sram_dq_out <= '0;
            rsp_rdata   <= '0;
        end else begin
            if (accept) begin
                sram_addr   <= req_addr;
                sram_dq_out <= req_wdata;
            end
            if (capture) begin
                rsp_rdata <= sram_dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int RD_CYC   = 9,
    parameter int HIZ_CYC  = 4,
    parameter int DRV_CYC  = 4,
    parameter int REC_CYC  = 1,
    parameter int TURN_CYC = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             accept,
    output logic             capture,
    output logic             cs_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe,
    output logic             ready,
    output logic             rsp_valid
);

    ctrl_state_e state_q, state_d;
    pin_ctl_t    pins_q;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign capture = (state_q == ST_RD_ACT) && cnt_zero;

    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    cnt_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_HIZ;
                        cnt_val = CNT_W'(HIZ_CYC - 1);
                    end else begin
                        state_d = ST_RD_ACT;
                        cnt_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_RD_ACT: begin
                if (cnt_zero) state_d = ST_RD_DONE;
            end
            ST_RD_DONE: begin
                if (TURN_CYC > 0) begin
                    state_d  = ST_RD_TURN;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(imax(TURN_CYC - 1, 0));
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_TURN: begin
                if (cnt_zero) state_d = ST_IDLE;
            end
            ST_WR_HIZ: begin
                if (cnt_zero) begin
                    state_d  = ST_WR_DRV;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(DRV_CYC - 1);
                end
            end
            ST_WR_DRV: begin
                if (cnt_zero) begin
                    state_d  = ST_WR_REC;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(REC_CYC - 1);
                end
            end
            ST_WR_REC: begin
                if (cnt_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pins_q  <= decode_pins(ST_IDLE);
        end else begin
            state_q <= state_d;
            pins_q  <= decode_pins(state_d);
        end
    end

    assign cs_n      = pins_q.cs_n;
    assign we_n      = pins_q.we_n;
    assign oe_n      = pins_q.oe_n;
    assign dq_oe     = pins_q.dq_oe;
    assign ready     = pins_q.ready;
    assign rsp_valid = pins_q.rsp;

    AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> we_n); // R3
    AST_DRV_NOT_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_n && !we_n && !cs_n)); // R7
    AST_DRV_DROPS_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (!dq_oe && $past(dq_oe))); // R5
    AST_WE_FALL_NO_DRV: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> !dq_oe); // R6
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cs_n && we_n && oe_n && !dq_oe)); // R11
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready); // R11

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int CLK_MHZ   = 125,
    parameter int T_RC_NS   = 70,
    parameter int T_AA_NS   = 70,
    parameter int T_ACS_NS  = 70,
    parameter int T_OE_NS   = 35,
    parameter int T_WC_NS   = 70,
    parameter int T_WP_NS   = 50,
    parameter int T_AW_NS   = 50,
    parameter int T_CW_NS   = 50,
    parameter int T_DW_NS   = 30,
    parameter int T_WHZ_NS  = 30,
    parameter int T_CHZ_NS  = 30,
    parameter int T_OHZ_NS  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    // Read: strobes low until every access path and the cycle time are met.
    localparam int C_RD   = imax(1, imax(imax(ns2cyc(T_AA_NS, CLK_MHZ), ns2cyc(T_ACS_NS, CLK_MHZ)),
                                         imax(ns2cyc(T_OE_NS, CLK_MHZ), ns2cyc(T_RC_NS, CLK_MHZ))));
    // Write: driver held off while the memory may still drive after WE falls.
    localparam int C_HIZ  = imax(1, ns2cyc(T_WHZ_NS, CLK_MHZ));
    localparam int C_LOW  = imax(ns2cyc(T_WP_NS, CLK_MHZ),
                                 imax(ns2cyc(T_AW_NS, CLK_MHZ), ns2cyc(T_CW_NS, CLK_MHZ)));
    localparam int C_DRV  = imax(1, imax(ns2cyc(T_DW_NS, CLK_MHZ), C_LOW - C_HIZ));
    localparam int C_REC  = imax(1, ns2cyc(T_WC_NS, CLK_MHZ) - C_HIZ - C_DRV);
    // Read-to-write release: done-cycle plus idle-cycle plus the write quiet phase count.
    localparam int C_REL  = imax(ns2cyc(T_CHZ_NS, CLK_MHZ), ns2cyc(T_OHZ_NS, CLK_MHZ));
    localparam int C_TURN = imax(0, C_REL - 2 - C_HIZ);
    localparam int C_MAX  = imax(imax(C_RD, C_HIZ), imax(imax(C_DRV, C_REC), C_TURN));
    localparam int CNT_W  = imax(1, $clog2(C_MAX + 1));

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;
    logic             accept;
    logic             capture;

    sram_seq_fsm #(
        .CNT_W    (CNT_W),
        .RD_CYC   (C_RD),
        .HIZ_CYC  (C_HIZ),
        .DRV_CYC  (C_DRV),
        .REC_CYC  (C_REC),
        .TURN_CYC (C_TURN)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .cnt_zero  (cnt_zero),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .accept    (accept),
        .capture   (capture),
        .cs_n      (sram_cs_n),
        .we_n      (sram_we_n),
        .oe_n      (sram_oe_n),
        .dq_oe     (sram_dq_oe),
        .ready     (req_ready),
        .rsp_valid (rsp_valid)
    );

    sram_delay_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .capture     (capture),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .sram_dq_in  (sram_dq_in),
        .sram_addr   (sram_addr),
        .sram_dq_out (sram_dq_out),
        .rsp_rdata   (rsp_rdata)
    );

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out))); // R8

endmodule

// File: tb/test_sram_ctrl.sv
`timescale 1ns/100ps
module test_sram_ctrl;

    localparam int AW = 15;
    localparam int DW = 8;
    localparam int MHZ = 125;
    localparam int PER = 8;
    localparam int RD_LAT = ((70 * MHZ + 999) / 1000) + 1;          // R2: 10
    localparam int WR_LAT = ((30 * MHZ + 999) / 1000) * 2 + 1 + 1;  // R12: 10

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] sram_addr;
    logic          sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out;
    logic [DW-1:0] sram_dq_in = '0;

    sram_ctrl i_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    always #(PER / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [DW-1:0] mem    [0:(1<<AW)-1];
    logic [DW-1:0] shadow [0:(1<<AW)-1];
    logic [DW-1:0] exp_q [$];
    int            acc_q [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: data valid only 70 ns after a stable selected address.
    realtime t_acc = 0.0;
    bit      acc_on = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    initial begin
        #0.5;
        forever begin
            if (!sram_cs_n && !sram_oe_n) begin
                if (!acc_on || sram_addr != acc_addr) t_acc = $realtime;
                acc_on = 1'b1;
                acc_addr = sram_addr;
                sram_dq_in = ($realtime - t_acc >= 70.0) ? mem[sram_addr] : ~mem[sram_addr];
            end else begin
                acc_on = 1'b0;
                sram_dq_in = 8'h5A;
            end
            #1;
        end
    end

    // Pin monitor
    logic p_cs = 1'b1, p_we = 1'b1, p_oe = 1'b1, p_drv = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dout = '0;
    int we_fall = -100, drv_on = -100, oe_fall = -100, rd_rel = -100, cs_fall = -100;
    int v_r3 = 0, v_r7 = 0, v_r8 = 0;
    always @(negedge clk) if (rst_n) begin
        if (!sram_oe_n && !sram_we_n) v_r3++;
        if (sram_dq_oe && !sram_oe_n) v_r7++;
        if (!p_cs && !sram_cs_n && (sram_addr != p_addr || sram_dq_out != p_dout)) v_r8++;
        if (p_cs && !sram_cs_n) begin
            if (cs_fall >= 0) chk((cyc - cs_fall) * PER >= 70, "R9 cs spacing ns", (cyc - cs_fall) * PER, 70);
            cs_fall = cyc;
        end
        if (p_we && !sram_we_n) we_fall = cyc;
        if (!p_oe && sram_oe_n) begin
            chk((cyc - oe_fall) * PER >= 70, "R2 read strobe ns", (cyc - oe_fall) * PER, 70);
            rd_rel = cyc;
        end
        if (p_oe && !sram_oe_n) oe_fall = cyc;
        if (!p_drv && sram_dq_oe) begin
            drv_on = cyc;
            chk((cyc - we_fall) * PER >= 30, "R6 drive after we fall ns", (cyc - we_fall) * PER, 30);
            chk((cyc - rd_rel) * PER >= 30, "R10 drive after read release ns", (cyc - rd_rel) * PER, 30);
        end
        if (!p_we && sram_we_n) begin
            chk((cyc - we_fall) * PER >= 50, "R4 we pulse ns", (cyc - we_fall) * PER, 50);
            chk(p_drv && (cyc - drv_on) * PER >= 30, "R5 data setup ns", (cyc - drv_on) * PER, 30);
            chk(!sram_dq_oe, "R5 driver off with we rise", int'(sram_dq_oe), 0);
            chk(p_oe, "R4 oe high in write", int'(p_oe), 1);
            if (!p_cs && p_drv) mem[p_addr] = p_dout;
        end
        p_cs = sram_cs_n; p_we = sram_we_n; p_oe = sram_oe_n; p_drv = sram_dq_oe;
        p_addr = sram_addr; p_dout = sram_dout_w();
    end

    function automatic logic [DW-1:0] sram_dout_w();
        return sram_dq_out;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected rsp", 1, 0);
        end else begin
            logic [DW-1:0] e;
            int a;
            e = exp_q.pop_front();
            a = acc_q.pop_front();
            chk(rsp_rdata == e, "R2 read data", int'(rsp_rdata), int'(e));
            chk(cyc - a == RD_LAT, "R2 read latency", cyc - a, RD_LAT);
        end
    end

    task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int t0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        t0 = cyc;
        if (wr) shadow[a] = d;
        else begin exp_q.push_back(shadow[a]); acc_q.push_back(t0); end
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~a; req_wdata = ~d;
        chk(!req_ready, "R11 ready drops after accept", int'(req_ready), 0);
        if (wr) begin
            while (!req_ready && cyc - t0 < 50) @(negedge clk);
            chk(cyc - t0 == WR_LAT, "R12 write ready latency", cyc - t0, WR_LAT);
        end
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) begin
            mem[i] = DW'(i * 7 + (i >> 8));
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes high", {sram_cs_n, sram_we_n, sram_oe_n}, 7);
        chk(!sram_dq_oe && !rsp_valid, "R1 driver and rsp off", {sram_dq_oe, rsp_valid}, 0);
        chk(req_ready, "R1 ready", int'(req_ready), 1);

        do_req(1'b1, 15'h0000, 8'h3C);
        do_req(1'b1, 15'h7FFF, 8'hC3);
        do_req(1'b0, 15'h0000, 8'h00);
        do_req(1'b0, 15'h7FFF, 8'h00);
        do_req(1'b0, 15'h1234, 8'h00);
        for (int k = 0; k < 6; k++) do_req(1'b1, AW'(k * 1111 + 5), DW'(k * 37 + 1));
        for (int k = 0; k < 6; k++) do_req(1'b0, AW'(k * 1111 + 5), 8'h00);
        // R10: read then write to the same word, then read back
        do_req(1'b0, 15'h2A2A, 8'h00);
        do_req(1'b1, 15'h2A2A, 8'hFF);
        do_req(1'b0, 15'h2A2A, 8'h00);
        do_req(1'b1, 15'h2A2A, 8'h00);
        do_req(1'b0, 15'h2A2A, 8'h00);
        do_req(1'b0, 15'h4000, 8'h00);
        do_req(1'b0, 15'h4000, 8'h00);

        for (int w = 0; w < 100 && exp_q.size() != 0; w++) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
        chk(v_r3 == 0, "R3 we high while oe low", v_r3, 0);
        chk(v_r7 == 0, "R7 no drive while oe low", v_r7, 0);
        chk(v_r8 == 0, "R8 address/data held while selected", v_r8, 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(PER * 150000);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule